// File: doc/BRIEF.md
# Stream Identifier Span Filter Matcher

This block sits between the event sources of a transaction-monitoring unit and its bank of event counters. Each incoming event arrives with an event code and a stream identifier. For every counter the block holds a configuration of three parts: an event selector, a span flag and a stream-match value. It raises that counter's count-enable pulse only when the event code equals the selector and the stream identifier passes the filter.

When the span flag is clear, the filter is an exact compare against the match value. When the span flag is set, the match value also encodes how many low bits to ignore. A run of trailing ones, together with the first zero above that run, marks the low bits that are don't-care. The remaining upper bits must match.

A static mode input can switch the block to a shared-filter arrangement. In that mode every counter takes its span flag and match value from counter 0, while each counter keeps its own event selector. Configuration is loaded through a simple single-cycle write port. The per-counter result is registered.

Top module: `sid_span_filter`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `cnt_en` is all zeros. Reset clears every selector, span flag and match value to zero, so after reset an event with code 0 and stream identifier 0 hits every counter.
- R2: With the effective span flag clear, a counter's filter passes only when `ev_sid` equals the effective match value in every bit.
- R3: With the effective span flag set, the don't-care mask covers the trailing ones of the match value plus the first zero above them. For example, match 0x42 passes identifiers 0x42 and 0x43 only, and any match value with bit 0 clear ignores only bit 0.
- R4: With the effective span flag set and a match value of all ones, every stream identifier passes.
- R5: A counter pulses only when `ev_code` equals its selector and its filter passes (logical AND).
- R6: No counter pulses in the cycle after a cycle in which `ev_valid` is low.
- R7: With `glob_mode` high, every counter uses counter 0's span flag and match value, while still comparing `ev_code` against its own selector.
- R8: With `glob_mode` low, each counter uses its own span flag and match value.
- R9: Write encoding: `wr_sel`=0 loads the event-type register of counter `wr_idx`, with the selector taken from `wr_data[15:0]` and the span flag from `wr_data[29]`. `wr_sel`=1 loads the match value from `wr_data[SID_W-1:0]`.
- R10: A write takes effect at the clock edge that captures it, so an event presented in that same cycle is judged with the old configuration. `cnt_en` for an event is valid exactly one cycle after the event is presented, and it lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_mode | input | 1 | 1: all counters share counter 0's filter settings |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 1 | 0: event-type register, 1: match register |
| wr_idx | input | IDX_W | Counter index written |
| wr_data | input | 32 | Write data |
| ev_valid | input | 1 | Event strobe |
| ev_code | input | 16 | Event code |
| ev_sid | input | SID_W | Stream identifier of the event |
| cnt_en | output | NUM_CNT | Registered per-counter count-enable pulses |

## Verification
The bench builds the block with four counters and an 8-bit stream identifier. At that width the bench sweeps every match value against every stream identifier, covering every possible don't-care mask length. Two counters run in span mode and two run in exact mode. A separate sweep in shared-filter mode checks that counters whose own registers disagree still follow counter 0. Directed cases cover the reset contents, selector mismatch, idle strobes, and an event that arrives in the same cycle as a configuration write.

// File: rtl/sidf_pkg.sv
// Package: shared constants and register selector type for the stream filter.
// Assumes a 32-bit configuration write word.
package sidf_pkg;
    localparam int EVT_W    = 16;  // event selector width, bits [15:0]
    localparam int SPAN_BIT = 29;  // span flag position in event-type word
    localparam int REG_W    = 32;  // configuration write word width

    typedef enum logic {
        CFG_EVTYPE = 1'b0,
        CFG_MATCH  = 1'b1
    } cfg_reg_e;
endpackage

// File: rtl/sidf_cfg_regs.sv
// Module: per-counter configuration storage (selector, span flag, match value).
// Assumes single-cycle writes; a write is visible after the capturing edge.
module sidf_cfg_regs
    import sidf_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int SID_W   = 32,
    parameter int IDX_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_sel,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [REG_W-1:0]                  wr_data,
    output logic [NUM_CNT-1:0][EVT_W-1:0]     sel_q,
    output logic [NUM_CNT-1:0]                span_q,
    output logic [NUM_CNT-1:0][SID_W-1:0]     match_q
);
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic hit_idx;
        assign hit_idx = wr_en && (wr_idx == IDX_W'(g));

        // Load this counter's event-type or match register on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[g]   <= '0;
                span_q[g]  <= 1'b0;
                match_q[g] <= '0;
            end else if (hit_idx) begin
                if (cfg_reg_e'(wr_sel) == CFG_MATCH) begin
                    match_q[g] <= wr_data[SID_W-1:0];
                end else begin
                    sel_q[g]  <= wr_data[EVT_W-1:0];
                    span_q[g] <= wr_data[SPAN_BIT];
                end
            end
        end
    end
endmodule

// File: rtl/sidf_span_match.sv
// Module: combinational stream-identifier filter for one counter.
// With span set, trailing ones plus the first zero above them are don't-care;
// an all-ones match value therefore masks every bit.
module sidf_span_match #(
    parameter int SID_W = 32
) (
    input  logic             span,
    input  logic [SID_W-1:0] match,
    input  logic [SID_W-1:0] sid,
    output logic             pass
);
    logic [SID_W-1:0] dc_mask;
    logic [SID_W-1:0] diff;

    // Derive the don't-care mask: x ^ (x+1) marks trailing ones and next zero.
    always_comb begin
        dc_mask = span ? (match ^ (match + SID_W'(1))) : '0;
        diff    = sid ^ match;
        pass    = ((diff & ~dc_mask) == '0);
    end
endmodule

// File: rtl/sid_span_filter.sv
// Module: top of the stream-identifier span filter matcher.
// Per counter: select effective filter (own or counter 0 in shared mode),
// match, AND with event-code selection, and register the pulse.
// Assumes SID_W <= 32 and a glob_mode level that is held static while counting.
module sid_span_filter
    import sidf_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int SID_W   = 32,
    localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glob_mode,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               ev_valid,
    input  logic [EVT_W-1:0]   ev_code,
    input  logic [SID_W-1:0]   ev_sid,
    output logic [NUM_CNT-1:0] cnt_en
);
    logic [NUM_CNT-1:0][EVT_W-1:0] cfg_sel;
    logic [NUM_CNT-1:0]            cfg_span;
    logic [NUM_CNT-1:0][SID_W-1:0] cfg_match;
    logic [NUM_CNT-1:0]            flt_pass;
    logic [NUM_CNT-1:0]            lane_hit;
    logic [NUM_CNT-1:0]            cnt_en_q;

    sidf_cfg_regs #(
        .NUM_CNT (NUM_CNT),
        .SID_W   (SID_W),
        .IDX_W   (IDX_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sel_q   (cfg_sel),
        .span_q  (cfg_span),
        .match_q (cfg_match)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
        logic             eff_span;
        logic [SID_W-1:0] eff_match;

        // Pick the filter source: counter 0 in shared mode, else own settings.
        always_comb begin
            eff_span  = glob_mode ? cfg_span[0]  : cfg_span[g];
            eff_match = glob_mode ? cfg_match[0] : cfg_match[g];
        end

        sidf_span_match #(
            .SID_W (SID_W)
        ) u_match (
            .span  (eff_span),
            .match (eff_match),
            .sid   (ev_sid),
            .pass  (flt_pass[g])
        );

        assign lane_hit[g] = ev_valid && (ev_code == cfg_sel[g]) && flt_pass[g];
    end

    // Register the per-counter decision: one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_en_q <= '0;
        else        cnt_en_q <= lane_hit;
    end

    assign cnt_en = cnt_en_q;
endmodule

// File: rtl/sid_span_filter_chk.sv
// Module: assertion checker bound to sid_span_filter.
// Observes ports and the configuration registers driven by the storage module.
module sid_span_filter_chk
    import sidf_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int SID_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          glob_mode,
    input logic                          ev_valid,
    input logic [EVT_W-1:0]              ev_code,
    input logic [SID_W-1:0]              ev_sid,
    input logic [NUM_CNT-1:0]            cnt_en,
    input logic [NUM_CNT-1:0][EVT_W-1:0] sel_q,
    input logic [NUM_CNT-1:0]            span_q,
    input logic [NUM_CNT-1:0][SID_W-1:0] match_q
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> (cnt_en == '0)); // R6

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        AST_CODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_valid && ev_code != sel_q[g]) |=> !cnt_en[g]); // R5

        AST_EXACT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
            (!glob_mode && ev_valid && !span_q[g] && ev_sid != match_q[g]) |=> !cnt_en[g]); // R2

        AST_EXACT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            (!glob_mode && ev_valid && ev_code == sel_q[g] && !span_q[g]
             && ev_sid == match_q[g]) |=> cnt_en[g]); // R8

        AST_ALLONES_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (!glob_mode && ev_valid && ev_code == sel_q[g] && span_q[g]
             && (&match_q[g])) |=> cnt_en[g]); // R4

        AST_GLOBAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (glob_mode && ev_valid && ev_code == sel_q[g] && ev_code == sel_q[0])
            |=> (cnt_en[g] == cnt_en[0])); // R7
    end
endmodule

bind sid_span_filter sid_span_filter_chk #(
    .NUM_CNT (NUM_CNT),
    .SID_W   (SID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_mode (glob_mode),
    .ev_valid  (ev_valid),
    .ev_code   (ev_code),
    .ev_sid    (ev_sid),
    .cnt_en    (cnt_en),
    .sel_q     (cfg_sel),
    .span_q    (cfg_span),
    .match_q   (cfg_match)
);

// File: tb/sid_span_filter_tb_top.sv
// Bench: exhaustive match-value by stream-identifier sweep at SID_W=8,
// with expected pulses computed from a bench-side configuration model.
module sid_span_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int SW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          glob_mode;
    logic          wr_en;
    logic          wr_sel;
    logic [IW-1:0] wr_idx;
    logic [31:0]   wr_data;
    logic          ev_valid;
    logic [15:0]   ev_code;
    logic [SW-1:0] ev_sid;
    logic [NC-1:0] cnt_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0]   m_sel   [NC];
    logic          m_span  [NC];
    logic [SW-1:0] m_match [NC];
    logic          m_glob;

    always #(CLK_PERIOD/2) clk = ~clk;

    sid_span_filter #(.NUM_CNT(NC), .SID_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .glob_mode(glob_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_sid(ev_sid),
        .cnt_en(cnt_en)
    );

    function automatic logic [NC-1:0] expect_vec(input logic v, input logic [15:0] code,
                                                 input logic [SW-1:0] sid);
        logic [NC-1:0] res;
        for (int i = 0; i < NC; i++) begin
            logic          sp;
            logic [SW-1:0] mt;
            logic [SW-1:0] mask;
            sp   = m_glob ? m_span[0]  : m_span[i];
            mt   = m_glob ? m_match[0] : m_match[i];
            mask = '0;
            if (sp) begin
                for (int b = 0; b < SW; b++) begin
                    mask[b] = 1'b1;
                    if (!mt[b]) break;
                end
            end
            res[i] = v && (code == m_sel[i]) && ((sid & ~mask) == (mt & ~mask));
        end
        return res;
    endfunction

    task automatic check_vec(input logic [NC-1:0] exp, input string tag);
        checks++;
        if (cnt_en !== exp) begin
            errors++;
            $display("FAIL %s: cnt_en=%b expected %b", tag, cnt_en, exp);
        end
    endtask

    task automatic wr(input logic sel, input int idx, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_idx = IW'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_match[idx] = data[SW-1:0];
        else begin m_sel[idx] = data[15:0]; m_span[idx] = data[29]; end
    endtask

    task automatic set_evt(input int idx, input logic span, input logic [15:0] sel);
        wr(1'b0, idx, (32'(span) << 29) | 32'(sel));
    endtask

    task automatic ev(input logic v, input logic [15:0] code, input logic [SW-1:0] sid,
                      input string tag);
        logic [NC-1:0] exp;
        ev_valid = v; ev_code = code; ev_sid = sid;
        exp = expect_vec(v, code, sid);
        @(negedge clk);
        check_vec(exp, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; glob_mode = 1'b0; m_glob = 1'b0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_idx = '0; wr_data = '0;
        ev_valid = 1'b1; ev_code = 16'h0; ev_sid = '0;
        for (int i = 0; i < NC; i++) begin m_sel[i] = '0; m_span[i] = 1'b0; m_match[i] = '0; end
        @(negedge clk); @(negedge clk);
        check_vec('0, "R1 during reset");
        ev_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_vec('0, "R1 after release");
        ev(1'b1, 16'h0, 8'h00, "R1 reset contents hit all");
        ev(1'b0, 16'h0, 8'h00, "R6 idle strobe");
        ev(1'b1, 16'h0, 8'h01, "R1 R2 reset exact miss");

        // R3 directed: 0x42 spans 0x42..0x43; 0x40 masks bit 0 only.
        set_evt(0, 1'b1, 16'h1); wr(1'b1, 0, 32'h42);
        set_evt(1, 1'b1, 16'h1); wr(1'b1, 1, 32'h40);
        set_evt(2, 1'b0, 16'h1); wr(1'b1, 2, 32'h42);
        set_evt(3, 1'b1, 16'h1); wr(1'b1, 3, 32'hFF);
        ev(1'b1, 16'h1, 8'h42, "R3 0x42 self");
        ev(1'b1, 16'h1, 8'h43, "R3 0x42 spans 0x43");
        ev(1'b1, 16'h1, 8'h40, "R3 0x42 excludes 0x40");
        ev(1'b1, 16'h1, 8'h41, "R3 low zero masks bit0");
        ev(1'b1, 16'h1, 8'h07, "R4 all ones passes");
        ev(1'b0, 16'h1, 8'h42, "R6 valid low");

        // R10: write in the same cycle as an event uses the old setting.
        wr_en = 1'b1; wr_sel = 1'b1; wr_idx = 2'd2; wr_data = 32'h10;
        ev_valid = 1'b1; ev_code = 16'h1; ev_sid = 8'h42;
        begin
            logic [NC-1:0] exp_old;
            exp_old = expect_vec(1'b1, 16'h1, 8'h42);
            @(negedge clk);
            wr_en = 1'b0; m_match[2] = 8'h10;
            check_vec(exp_old, "R10 old config in write cycle");
        end
        ev(1'b1, 16'h1, 8'h42, "R10 new config next cycle");
        ev(1'b1, 16'h1, 8'h10, "R9 match write landed");
        ev(1'b0, 16'h1, 8'h10, "R10 one-cycle pulse");

        // R5: selectors differ, filters open; sweep codes.
        for (int i = 0; i < NC; i++) begin set_evt(i, 1'b1, 16'(i + 1)); wr(1'b1, i, 32'hFF); end
        for (int c = 0; c < 7; c++) ev(1'b1, 16'(c), 8'(c * 37), "R5 code select");
        ev(1'b1, 16'h1001, 8'h00, "R9 high code bits compared");

        // Exhaustive sweep: spans on counters 0,1, exact on 2,3.
        for (int m = 0; m < 256; m++) begin
            set_evt(0, 1'b1, 16'h1); wr(1'b1, 0, 32'(m));
            set_evt(1, 1'b1, 16'h1); wr(1'b1, 1, 32'(m ^ 8'hA5));
            set_evt(2, 1'b0, 16'h1); wr(1'b1, 2, 32'(m));
            set_evt(3, 1'b0, 16'h1); wr(1'b1, 3, 32'(~m & 8'hFF));
            for (int s = 0; s < 256; s++) ev(1'b1, 16'h1, 8'(s), "R2 R3 R4 R8 sweep");
        end
        ev_valid = 1'b0;

        // R7: shared mode; counter 0 spans 0x42, others disagree, counter 2 off-code.
        set_evt(0, 1'b1, 16'h1); wr(1'b1, 0, 32'h42);
        set_evt(1, 1'b0, 16'h1); wr(1'b1, 1, 32'h00);
        set_evt(2, 1'b0, 16'h2); wr(1'b1, 2, 32'h43);
        set_evt(3, 1'b1, 16'h1); wr(1'b1, 3, 32'hFF);
        glob_mode = 1'b1; m_glob = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 256; s++) ev(1'b1, 16'h1, 8'(s), "R7 shared filter");
        ev(1'b1, 16'h2, 8'h42, "R7 own selector kept");
        ev(1'b0, 16'h1, 8'h42, "R6 idle in shared mode");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule